// File: doc/BRIEF.md
# Memory ECC Error Log Register

This block keeps a record of where in DRAM a read error was seen, for use by error-handling software. An ECC checker sends it one report per read data transfer. A report carries a correctable-error flag and an uncorrectable-error flag. It also carries the column, row, bank and rank of the failing location and the 8-bit syndrome of the first failing quadword. The block keeps one location and syndrome, plus two status bits, in a single 64-bit read-only word.

A correctable capture guards the logged location only against later correctable errors; an uncorrectable error still replaces it. An uncorrectable capture freezes the location against every later error. The two status bits are released by separate one-cycle clear pulses. These pulses arrive when software clears the matching bits of a companion error status register kept elsewhere.

The log is sticky: a power-on reset zeroes it, and a core reset only clears the read data register of the read port.

Top module: `ecc_err_log`

## Requirements
- R1: The read word is laid out as column 63:48, row 47:32, bank 31:29, rank 28:27, syndrome 23:16, uncorrectable status in bit 1 and correctable status in bit 0; bits 26:24 and 15:2 always read as zero.
- R2: An uncorrectable report while bit 1 is clear logs the report's location and syndrome and sets bit 1 on the edge that samples it.
- R3: While bit 1 is set and no uncorrectable clear arrives, the logged location and syndrome do not change for any report; a correctable report in that time still sets bit 0.
- R4: A correctable report while both status bits are clear logs the report's location and syndrome and sets bit 0.
- R5: While bit 0 is set and no correctable clear arrives, a further correctable report leaves the logged location and syndrome unchanged.
- R6: An uncorrectable report while only bit 0 is set replaces the logged location and syndrome and sets bit 1, keeping bit 0 set.
- R7: A correctable clear pulse clears bit 0 only; an uncorrectable clear pulse clears bit 1 only; each takes effect on the edge that samples it.
- R8: Clear pulses leave the logged location and syndrome at their last values.
- R9: When both flags are reported in one cycle, both status bits are set and the report's location and syndrome are logged.
- R10: A clear pulse and a new report of the same kind in the same cycle leave the status bit set and log the new report.
- R11: Power-on reset zeroes the whole log; a core reset zeroes only the read data output and leaves the log intact.
- R12: A read enable sampled high on an edge loads the read data output with the log word as it stood before that edge; with read enable low the output holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| core_rst_n | input | 1 | Core reset, active low, asynchronous, clears read data only |
| ce_in | input | 1 | Correctable error reported this cycle |
| ue_in | input | 1 | Uncorrectable error reported this cycle |
| err_col | input | 16 | Column address of the failing transfer |
| err_row | input | 16 | Row address of the failing transfer |
| err_bank | input | 3 | Bank of the failing transfer |
| err_rank | input | 2 | Rank of the failing transfer |
| err_synd | input | 8 | Syndrome of the first failing quadword |
| ce_clr | input | 1 | Correctable status cleared by software |
| ue_clr | input | 1 | Uncorrectable status cleared by software |
| rd_en | input | 1 | Read request |
| rd_data | output | 64 | Read data, the packed log word |

## Verification
A report or clear pulse changes the log on the same rising edge that samples it. A read enable raised at the following edge returns the new word on rd_data at that edge, so each result is due two edges after its stimulus is applied. The bench drives every input at a falling edge. Each read task samples rd_data at the falling edge after its read edge, and every check therefore lands one full edge after the value settles. A core reset is asynchronous and is checked within the same half cycle in which it is asserted.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
   localparam int LOG_W    = 64;
   localparam int COL_FW   = 16;
   localparam int COL_LSB  = 48;
   localparam int ROW_FW   = 16;
   localparam int ROW_LSB  = 32;
   localparam int BANK_FW  = 3;
   localparam int BANK_LSB = 29;
   localparam int RANK_FW  = 2;
   localparam int RANK_LSB = 27;
   localparam int SYND_FW  = 8;
   localparam int SYND_LSB = 16;
   localparam int UE_BIT   = 1;
   localparam int CE_BIT   = 0;

   typedef struct packed {
      logic [COL_FW-1:0]  col;
      logic [ROW_FW-1:0]  row;
      logic [BANK_FW-1:0] bank;
      logic [RANK_FW-1:0] rank;
      logic [SYND_FW-1:0] synd;
   } err_loc_t;
endpackage

// File: rtl/ecc_log_zext.sv
module ecc_log_zext #(
   parameter int IW = 8,
   parameter int OW = 8
) (
   input  logic [IW-1:0] din,
   output logic [OW-1:0] dout
);
   if (IW < 1 || IW > OW) begin : g_bad_width
      $error("ecc_log_zext: input width %0d does not fit field width %0d", IW, OW);
      assign dout = '0;
   end else if (IW == OW) begin : g_direct
      assign dout = din;
   end else begin : g_pad
      assign dout = {{(OW-IW){1'b0}}, din};
   end
endmodule

// File: rtl/ecc_log_ctrl.sv
module ecc_log_ctrl (
   input  logic clk,
   input  logic por_n,
   input  logic ce_in,
   input  logic ue_in,
   input  logic ce_clr,
   input  logic ue_clr,
   output logic ce_sts,
   output logic ue_sts,
   output logic load
);
   logic ue_open;
   logic ce_open;

   // A lock counts as released when its clear lands in the same cycle.
   assign ue_open = ~ue_sts | ue_clr;
   assign ce_open = ~ce_sts | ce_clr;
   assign load    = (ue_in & ue_open) | (ce_in & ce_open & ue_open);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         ce_sts <= 1'b0;
         ue_sts <= 1'b0;
      end else begin
         ce_sts <= ce_in | (ce_sts & ~ce_clr);
         ue_sts <= ue_in | (ue_sts & ~ue_clr);
      end
   end

   a_r2_ue_sets: assert property (@(posedge clk) disable iff (!por_n)
      ue_in |=> ue_sts);
   a_r4_ce_sets: assert property (@(posedge clk) disable iff (!por_n)
      ce_in |=> ce_sts);
   a_r7_ce_clears: assert property (@(posedge clk) disable iff (!por_n)
      (ce_clr && !ce_in) |=> !ce_sts);
   a_r7_ue_clears: assert property (@(posedge clk) disable iff (!por_n)
      (ue_clr && !ue_in) |=> !ue_sts);
   a_r7_ce_kept_by_ue_clr: assert property (@(posedge clk) disable iff (!por_n)
      (ce_sts && !ce_clr) |=> ce_sts);
   a_r9_both_set: assert property (@(posedge clk) disable iff (!por_n)
      (ce_in && ue_in) |=> (ce_sts && ue_sts));
endmodule

// File: rtl/ecc_log_store.sv
module ecc_log_store
   import ecc_log_pkg::*;
(
   input  logic     clk,
   input  logic     por_n,
   input  logic     load,
   input  err_loc_t loc_in,
   output err_loc_t loc_q
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         loc_q <= '0;
      end else if (load) begin
         loc_q <= loc_in;
      end
   end

   a_r8_hold_without_load: assert property (@(posedge clk) disable iff (!por_n)
      !load |=> $stable(loc_q));
endmodule

// File: rtl/ecc_log_rdport.sv
module ecc_log_rdport
   import ecc_log_pkg::*;
#(
   parameter bit RD_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  err_loc_t         loc,
   input  logic             ce_sts,
   input  logic             ue_sts,
   output logic [LOG_W-1:0] rd_data
);
   logic [LOG_W-1:0] word;

   always_comb begin
      word = '0;
      word[COL_LSB  +: COL_FW]  = loc.col;
      word[ROW_LSB  +: ROW_FW]  = loc.row;
      word[BANK_LSB +: BANK_FW] = loc.bank;
      word[RANK_LSB +: RANK_FW] = loc.rank;
      word[SYND_LSB +: SYND_FW] = loc.synd;
      word[UE_BIT]              = ue_sts;
      word[CE_BIT]              = ce_sts;
   end

   if (RD_REG) begin : g_registered
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_data <= '0;
         end else if (rd_en) begin
            rd_data <= word;
         end
      end

      a_r12_read_loads: assert property (@(posedge clk) disable iff (!rst_n)
         rd_en |=> (rd_data == $past(word)));
      a_r12_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_en |=> $stable(rd_data));
   end else begin : g_direct
      assign rd_data = (rd_en && rst_n) ? word : '0;
   end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
   import ecc_log_pkg::*;
#(
   parameter int COL_W  = 16,
   parameter int ROW_W  = 16,
   parameter int BANK_W = 3,
   parameter int RANK_W = 2,
   parameter int SYND_W = 8,
   parameter bit RD_REG = 1'b1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              core_rst_n,
   input  logic              ce_in,
   input  logic              ue_in,
   input  logic [COL_W-1:0]  err_col,
   input  logic [ROW_W-1:0]  err_row,
   input  logic [BANK_W-1:0] err_bank,
   input  logic [RANK_W-1:0] err_rank,
   input  logic [SYND_W-1:0] err_synd,
   input  logic              ce_clr,
   input  logic              ue_clr,
   input  logic              rd_en,
   output logic [LOG_W-1:0]  rd_data
);
   localparam int LOC_BITS = COL_FW + ROW_FW + BANK_FW + RANK_FW + SYND_FW;

   if (LOC_BITS != $bits(err_loc_t)) begin : g_bad_layout
      $error("ecc_err_log: field widths do not add up to the location record");
   end

   err_loc_t loc_in;
   err_loc_t loc_q;
   logic     ce_sts;
   logic     ue_sts;
   logic     load;
   logic     rd_rst_n;

   ecc_log_zext #(.IW(COL_W),  .OW(COL_FW))  u_zx_col  (.din(err_col),  .dout(loc_in.col));
   ecc_log_zext #(.IW(ROW_W),  .OW(ROW_FW))  u_zx_row  (.din(err_row),  .dout(loc_in.row));
   ecc_log_zext #(.IW(BANK_W), .OW(BANK_FW)) u_zx_bank (.din(err_bank), .dout(loc_in.bank));
   ecc_log_zext #(.IW(RANK_W), .OW(RANK_FW)) u_zx_rank (.din(err_rank), .dout(loc_in.rank));
   ecc_log_zext #(.IW(SYND_W), .OW(SYND_FW)) u_zx_synd (.din(err_synd), .dout(loc_in.synd));

   ecc_log_ctrl u_ctrl (
      .clk    (clk),
      .por_n  (por_n),
      .ce_in  (ce_in),
      .ue_in  (ue_in),
      .ce_clr (ce_clr),
      .ue_clr (ue_clr),
      .ce_sts (ce_sts),
      .ue_sts (ue_sts),
      .load   (load)
   );

   ecc_log_store u_store (
      .clk    (clk),
      .por_n  (por_n),
      .load   (load),
      .loc_in (loc_in),
      .loc_q  (loc_q)
   );

   // The log is sticky: only the read register sees the core reset.
   assign rd_rst_n = por_n & core_rst_n;

   ecc_log_rdport #(.RD_REG(RD_REG)) u_rdport (
      .clk     (clk),
      .rst_n   (rd_rst_n),
      .rd_en   (rd_en),
      .loc     (loc_q),
      .ce_sts  (ce_sts),
      .ue_sts  (ue_sts),
      .rd_data (rd_data)
   );

   a_r3_ue_freeze: assert property (@(posedge clk) disable iff (!por_n)
      (ue_sts && !ue_clr) |=> $stable(loc_q));
   a_r5_ce_freeze: assert property (@(posedge clk) disable iff (!por_n)
      (ce_sts && !ce_clr && !ue_in) |=> $stable(loc_q));
   a_r6_ue_overwrite: assert property (@(posedge clk) disable iff (!por_n)
      (ue_in && !ue_sts) |=> (loc_q == $past(loc_in)));
   a_r10_ue_clr_race: assert property (@(posedge clk) disable iff (!por_n)
      (ue_in && ue_clr) |=> (ue_sts && loc_q == $past(loc_in)));
   a_r4_ce_capture: assert property (@(posedge clk) disable iff (!por_n)
      (ce_in && !ce_sts && !ue_sts) |=> (loc_q == $past(loc_in)));
endmodule

// File: tb/ecc_err_log_bench.sv
`timescale 1ns/1ps
module ecc_err_log_bench;
   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        core_rst_n = 1'b1;
   logic        ce_in = 1'b0, ue_in = 1'b0, ce_clr = 1'b0, ue_clr = 1'b0, rd_en = 1'b0;
   logic [15:0] err_col = '0, err_row = '0;
   logic [2:0]  err_bank = '0;
   logic [1:0]  err_rank = '0;
   logic [7:0]  err_synd = '0;
   logic [63:0] rd_data;
   logic [63:0] got;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   ecc_err_log u_ecc_err_log (
      .clk(clk), .por_n(por_n), .core_rst_n(core_rst_n),
      .ce_in(ce_in), .ue_in(ue_in),
      .err_col(err_col), .err_row(err_row), .err_bank(err_bank),
      .err_rank(err_rank), .err_synd(err_synd),
      .ce_clr(ce_clr), .ue_clr(ue_clr), .rd_en(rd_en), .rd_data(rd_data)
   );

   typedef struct {
      logic [15:0] col;
      logic [15:0] row;
      logic [2:0]  bank;
      logic [1:0]  rank;
      logic [7:0]  synd;
   } rpt_t;

   // R1 layout
   function automatic logic [63:0] pk(rpt_t r, logic ue, logic ce);
      return {r.col, r.row, r.bank, r.rank, 3'b000, r.synd, 14'd0, ue, ce};
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Drives one cycle of inputs starting at a falling edge.
   task automatic drive(input logic ce, input logic ue, input rpt_t r,
                        input logic cclr, input logic uclr);
      ce_in = ce; ue_in = ue; ce_clr = cclr; ue_clr = uclr;
      err_col = r.col; err_row = r.row; err_bank = r.bank;
      err_rank = r.rank; err_synd = r.synd;
      @(negedge clk);
      ce_in = 1'b0; ue_in = 1'b0; ce_clr = 1'b0; ue_clr = 1'b0;
   endtask

   task automatic rd(output logic [63:0] v);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      v = rd_data;
   endtask

   rpt_t rz = '{16'h0, 16'h0, 3'd0, 2'd0, 8'h0};
   rpt_t ra = '{16'h1234, 16'h5678, 3'd2, 2'd1, 8'h3C};
   rpt_t rb = '{16'h0BAD, 16'h0F00, 3'd5, 2'd2, 8'h81};
   rpt_t rc = '{16'hC0DE, 16'hBEEF, 3'd6, 2'd3, 8'h5A};
   rpt_t rd_ = '{16'h1111, 16'h2222, 3'd1, 2'd0, 8'h11};
   rpt_t re = '{16'h3333, 16'h4444, 3'd3, 2'd1, 8'h22};
   rpt_t rf = '{16'hFFFF, 16'hFFFF, 3'd7, 2'd3, 8'hFF};
   rpt_t rg = '{16'h0A0A, 16'h0B0B, 3'd4, 2'd2, 8'h44};
   rpt_t rh = '{16'h7777, 16'h0001, 3'd0, 2'd1, 8'h66};
   rpt_t ri = '{16'h8001, 16'h9002, 3'd7, 2'd0, 8'h99};
   rpt_t rj = '{16'h4242, 16'h2424, 3'd5, 2'd3, 8'hA5};

   task automatic t_reset();
      check("R11 por zeroes read data", rd_data, 64'd0);
      rd(got); check("R11 por zeroes log", got, 64'd0);
   endtask

   task automatic t_ce_path();
      drive(1, 0, ra, 0, 0); rd(got); check("R4 ce capture", got, pk(ra, 0, 1));
      drive(1, 0, rb, 0, 0); rd(got); check("R5 ce lock", got, pk(ra, 0, 1));
   endtask

   task automatic t_ue_path();
      drive(0, 1, rc, 0, 0); rd(got); check("R6 ue overwrites ce log", got, pk(rc, 1, 1));
      drive(0, 1, rd_, 0, 0); rd(got); check("R3 ue lock vs ue", got, pk(rc, 1, 1));
      drive(1, 0, re, 0, 0); rd(got); check("R3 ue lock vs ce", got, pk(rc, 1, 1));
   endtask

   task automatic t_clears();
      drive(0, 0, rz, 1, 0); rd(got); check("R7 R8 ce clear only", got, pk(rc, 1, 0));
      drive(1, 0, re, 0, 0); rd(got); check("R3 ce sets bit0 fields frozen", got, pk(rc, 1, 1));
      drive(0, 0, rz, 0, 1); rd(got); check("R7 R8 ue clear only", got, pk(rc, 0, 1));
      drive(0, 0, rz, 1, 0); rd(got); check("R8 fields kept", got, pk(rc, 0, 0));
   endtask

   task automatic t_fresh_ue();
      drive(0, 1, rf, 0, 0); rd(got); check("R2 fresh ue capture", got, pk(rf, 1, 0));
      check("R1 reserved 26:24 zero", {61'd0, got[26:24]}, 64'd0);
      check("R1 reserved 15:2 zero", {50'd0, got[15:2]}, 64'd0);
   endtask

   task automatic t_races();
      drive(0, 1, rg, 0, 1); rd(got); check("R10 ue clear with new ue", got, pk(rg, 1, 0));
      drive(0, 0, rz, 0, 1);
      drive(1, 0, rh, 0, 0); rd(got); check("R4 ce after ue clear", got, pk(rh, 0, 1));
      drive(1, 0, ri, 1, 0); rd(got); check("R10 ce clear with new ce", got, pk(ri, 0, 1));
      drive(0, 0, rz, 1, 0);
      drive(1, 1, rj, 0, 0); rd(got); check("R9 both flags", got, pk(rj, 1, 1));
   endtask

   task automatic t_read_hold();
      drive(0, 0, rz, 1, 1);
      check("R12 no read holds output", rd_data, pk(rj, 1, 1));
      rd(got); check("R12 read after clear", got, pk(rj, 0, 0));
   endtask

   task automatic t_core_reset();
      core_rst_n = 1'b0;
      #1 check("R11 core reset clears read data", rd_data, 64'd0);
      @(negedge clk); core_rst_n = 1'b1;
      rd(got); check("R11 log sticky over core reset", got, pk(rj, 0, 0));
   endtask

   task automatic t_por();
      drive(1, 1, ra, 0, 0);
      por_n = 1'b0;
      @(negedge clk); por_n = 1'b1;
      rd(got); check("R11 por zeroes log again", got, 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ce_path();
      t_ue_path();
      t_clears();
      t_fresh_ue();
      t_races();
      t_read_hold();
      t_core_reset();
      t_por();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule